// File: doc/BRIEF.md
# Reduced boundary-scan test port

This block is the test-access port of a memory device that supports only part of the IEEE 1149.1 instruction set. A standard 16-state controller, stepped by the scan clock and the mode-select input, routes the serial path through one of four registers. The choices are a 3-bit instruction register, a 32-bit identification register, a single bypass bit and a boundary register. The boundary register samples a parameterised vector of device pins.

The port can only observe. Two boundary instructions can also force the device outputs to high impedance through `out_float`. Nothing in the block drives device pins, and there is no preload. Pin values arrive from the fast device clock domain, so each one passes through a two-flop synchroniser clocked by the scan clock before it can be captured. Serial output changes on the falling scan-clock edge.

Top module: `scanport_top`

## Requirements
- R1: The controller follows the standard 16-state transitions on `mode_sel` at each rising `scan_clk` edge. In Shift-IR the instruction register shifts from `scan_in` to `scan_out`, least significant bit first, so shifted data reappears three clocks later.
- R2: Capture-IR loads 3'b001 into the instruction shift stage. A shifted opcode takes effect, including its effect on `out_float`, only when the controller passes through Update-IR.
- R3: After reset, and after any entry into Test-Logic-Reset, the active instruction is IDCODE (3'b001). Under IDCODE, Capture-DR loads the 32-bit `ID_CODE`, whose bit 0 is 1, and Shift-DR emits it bit 0 first.
- R4: Five consecutive rising edges with `mode_sel` high reach Test-Logic-Reset from any state, which restores IDCODE and clears `out_float`.
- R5: SAMPLE (3'b100) selects the boundary register. Capture-DR loads the synchronised `pins_in`, which must be stable for two scan-clock edges, and Shift-DR emits pin 0 first. `out_float` stays low.
- R6: EXTEST (3'b000) and SAMPLE-Z (3'b010) both select and capture the boundary register the same way as SAMPLE, and both hold `out_float` high.
- R7: BYPASS (3'b111) places one bit between `scan_in` and `scan_out`. That bit captures 0 in Capture-DR, then delays `scan_in` by one clock in Shift-DR.
- R8: The reserved codes 3'b011, 3'b101 and 3'b110 behave as BYPASS and leave `out_float` low.
- R9: `scan_out` and `scan_out_en` change only on the falling `scan_clk` edge. `scan_out_en` is high exactly in Shift-IR and Shift-DR.
- R10: Update-DR has no effect. The active instruction and `out_float` are unchanged, and the next capture shows the pins rather than the data that was shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock; the controller and registers act on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to Test-Logic-Reset |
| mode_sel | input | 1 | Mode select that steers the controller |
| scan_in | input | 1 | Serial data in |
| pins_in | input | PIN_W | Device pin values from the fast clock domain |
| scan_out | output | 1 | Serial data out, updated on the falling edge |
| scan_out_en | output | 1 | High while `scan_out` is driven (shift states only) |
| out_float | output | 1 | Forces the device outputs to high impedance |

## Verification
Every internal state of this block shows up at the serial output within one scan. A controller that strays from the standard transitions misroutes the next scan, and the captured pattern, ID value or bypass delay then comes out wrong within a few clocks. A wrong active instruction shows up immediately on `out_float`, or at the next Capture-DR as the wrong register length or content. A preload that should not exist shows up on the following capture, when shifted data appears in place of the pin values.

// File: rtl/scanport_pkg.sv
// Shared types for the reduced scan port: controller states, opcodes and
// opcode decode helpers. Assumes a 3-bit instruction register.
package scanport_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    // Opcodes that route the boundary register.
    function automatic logic op_is_boundary(input logic [IR_W-1:0] op);
        return (op == OP_EXTEST) || (op == OP_SAMPLEZ) || (op == OP_SAMPLE);
    endfunction

    // Opcodes that force device outputs to high impedance.
    function automatic logic op_floats(input logic [IR_W-1:0] op);
        return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
    endfunction

endpackage

// File: rtl/scanport_fsm.sv
// Sixteen-state test controller. Advances on each rising scan clock from
// mode_sel. Assumes a synchronous active-low reset into the reset state.
module scanport_fsm
    import scanport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e st
);

    tap_state_e nxt;

    // Next-state selection per the standard transition graph.
    always_comb begin
        unique case (st)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RESET;
        else        st <= nxt;
    end

    // R4: five high mode_sel edges always land in the reset state.
    a_r4_five_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (st == ST_RESET));

endmodule

// File: rtl/scanport_ir.sv
// Instruction register: a shift stage loaded in Capture-IR and a holding
// register committed in Update-IR. Assumes the controller state as input.
module scanport_ir
    import scanport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  tap_state_e      st,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] active_ir
);

    logic [IR_W-1:0] shreg;

    // Shift stage: capture fixed pattern, then shift LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)               shreg <= '0;
        else if (st == ST_CAP_IR) shreg <= IR_CAPTURE;
        else if (st == ST_SH_IR)  shreg <= {tdi, shreg[IR_W-1:1]};
    end

    // Holding register: IDCODE on reset, new opcode on update.
    always_ff @(posedge clk) begin
        if (!rst_n)               active_ir <= OP_IDCODE;
        else if (st == ST_RESET)  active_ir <= OP_IDCODE;
        else if (st == ST_UPD_IR) active_ir <= shreg;
    end

    assign ir_so = shreg[0];

    // R2: the active instruction moves only via update or reset.
    a_r2_ir_commit_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_ir) |->
            ($past(st) == ST_UPD_IR || $past(st) == ST_RESET || !$past(rst_n)));

endmodule

// File: rtl/scanport_dr.sv
// Data registers: bypass bit, identification register and boundary register
// fed by two-flop synchronisers. Assumes pins_in is asynchronous to clk.
module scanport_dr
    import scanport_pkg::*;
#(
    parameter int          PIN_W   = 16,
    parameter logic [31:0] ID_CODE = 32'h5A3C_0E71
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tap_state_e       st,
    input  logic             tdi,
    input  logic [IR_W-1:0]  active_ir,
    input  logic [PIN_W-1:0] pins_in,
    output logic             dr_so
);

    localparam int ID_W = $bits(ID_CODE);

    logic             sel_bsr, sel_id, sel_byp;
    logic [PIN_W-1:0] sync1, sync2, bsr;
    logic [ID_W-1:0]  idr;
    logic             byp;

    assign sel_bsr = op_is_boundary(active_ir);
    assign sel_id  = (active_ir == OP_IDCODE);
    assign sel_byp = !sel_bsr && !sel_id;

    // Two-flop synchroniser for every sampled pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pins_in;
            sync2 <= sync1;
        end
    end

    // Boundary register: snapshot synchronised pins, shift LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)                           bsr <= '0;
        else if (sel_bsr && st == ST_CAP_DR)  bsr <= sync2;
        else if (sel_bsr && st == ST_SH_DR)   bsr <= {tdi, bsr[PIN_W-1:1]};
    end

    // Identification register: reload constant, shift LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idr <= ID_CODE;
        else if (sel_id && st == ST_CAP_DR)  idr <= ID_CODE;
        else if (sel_id && st == ST_SH_DR)   idr <= {tdi, idr[ID_W-1:1]};
    end

    // Bypass bit: capture zero, then single-stage delay.
    always_ff @(posedge clk) begin
        if (!rst_n)                           byp <= 1'b0;
        else if (sel_byp && st == ST_CAP_DR)  byp <= 1'b0;
        else if (sel_byp && st == ST_SH_DR)   byp <= tdi;
    end

    // Serial output of the selected data register.
    always_comb begin
        if (sel_bsr)     dr_so = bsr[0];
        else if (sel_id) dr_so = idr[0];
        else             dr_so = byp;
    end

    // R7: bypass bit holds zero right after capture.
    a_r7_bypass_captures_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_CAP_DR && $past(sel_byp)) |-> (byp == 1'b0));

    // R3: the identification value presents a 1 first after capture.
    a_r3_id_lsb_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_CAP_DR && $past(sel_id)) |-> (idr[0] == 1'b1));

endmodule

// File: rtl/scanport_top.sv
// Reduced boundary-scan port top: controller, instruction and data registers,
// falling-edge serial output and output-float control. Observes pins only.
module scanport_top
    import scanport_pkg::*;
#(
    parameter int          PIN_W   = 16,
    parameter logic [31:0] ID_CODE = 32'h5A3C_0E71
) (
    input  logic             scan_clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             scan_in,
    input  logic [PIN_W-1:0] pins_in,
    output logic             scan_out,
    output logic             scan_out_en,
    output logic             out_float
);

    tap_state_e      st;
    logic [IR_W-1:0] active_ir;
    logic            ir_so, dr_so;

    scanport_fsm u_fsm (
        .clk   (scan_clk),
        .rst_n (rst_n),
        .tms   (mode_sel),
        .st    (st)
    );

    scanport_ir u_ir (
        .clk       (scan_clk),
        .rst_n     (rst_n),
        .st        (st),
        .tdi       (scan_in),
        .ir_so     (ir_so),
        .active_ir (active_ir)
    );

    scanport_dr #(.PIN_W(PIN_W), .ID_CODE(ID_CODE)) u_dr (
        .clk       (scan_clk),
        .rst_n     (rst_n),
        .st        (st),
        .tdi       (scan_in),
        .active_ir (active_ir),
        .pins_in   (pins_in),
        .dr_so     (dr_so)
    );

    assign out_float = op_floats(active_ir);

    // Falling-edge retiming of serial output and its enable.
    always_ff @(negedge scan_clk) begin
        if (!rst_n) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out    <= (st == ST_SH_IR) ? ir_so : dr_so;
            scan_out_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
        end
    end

    // R9: enable seen at a rising edge implies a shift state.
    a_r9_enable_only_shift: assert property (@(posedge scan_clk) disable iff (!rst_n)
        scan_out_en |-> (st == ST_SH_IR || st == ST_SH_DR));

    // R6: float can only begin through an instruction update.
    a_r6_float_rises_on_update: assert property (@(posedge scan_clk) disable iff (!rst_n)
        $rose(out_float) |-> ($past(st) == ST_UPD_IR));

endmodule

// File: tb/tb_scanport_top.sv
module tb_scanport_top;

    localparam int          PIN_W = 16;
    localparam logic [31:0] ID    = 32'h5A3C_0E71;

    logic             tck = 1'b0;
    logic             rst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [PIN_W-1:0] pins = '0;
    logic             tdo, tdo_en, flt;

    int   n_chk = 0;
    int   n_bad = 0;
    logic s_tdo, s_en, pre_flt, en_ok;
    logic [63:0] got;

    scanport_top #(.PIN_W(PIN_W), .ID_CODE(ID)) dut (
        .scan_clk(tck), .rst_n(rst_n), .mode_sel(tms), .scan_in(tdi),
        .pins_in(pins), .scan_out(tdo), .scan_out_en(tdo_en), .out_float(flt)
    );

    always #10 tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample just after it.
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
        #5;
        s_tdo = tdo;
        s_en  = tdo_en;
    endtask

    // Full scan from idle, back to idle; records float before update.
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout);
        dout  = '0;
        en_ok = 1'b1;
        step(1, 0);
        if (is_ir) step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = s_tdo;
            if (s_en !== 1'b1) en_ok = 1'b0;
        end
        step(1, 0);
        pre_flt = flt;
        step(0, 0);
        step(0, 0);
    endtask

    task automatic load_ir(input logic [2:0] op);
        logic [63:0] d;
        scan(1, 3, {61'b0, op}, d);
    endtask

    task automatic t_reset;
        check("R3 reset float", {63'b0, flt}, 64'd0);
        check("R9 reset enable", {63'b0, tdo_en}, 64'd0);
        scan(0, 32, 64'd0, got);
        check("R3 idcode after reset", got, {32'b0, ID});
        check("R3 id lsb", {63'b0, got[0]}, 64'd1);
        check("R9 enable in shift", {63'b0, en_ok}, 64'd1);
        check("R9 enable idle", {63'b0, s_en}, 64'd0);
    endtask

    task automatic t_ir_path;
        scan(1, 6, 64'b100_101, got);
        check("R2 ir capture pattern", {61'b0, got[2:0]}, 64'b001);
        check("R1 ir shift-through", {61'b0, got[5:3]}, 64'b101);
        check("R2 ir committed", {63'b0, flt}, 64'd0);
    endtask

    task automatic t_bypass;
        load_ir(3'b111);
        scan(0, 8, 64'hB3, got);
        check("R7 bypass delay", got, 64'h66);
        check("R7 bypass no float", {63'b0, flt}, 64'd0);
    endtask

    task automatic t_reserved;
        for (int c = 0; c < 8; c++) begin
            if (c == 3 || c == 5 || c == 6) begin
                load_ir(c[2:0]);
                scan(0, 4, 64'b1011, got);
                check("R8 reserved acts as bypass", got, 64'b0110);
                check("R8 reserved no float", {63'b0, flt}, 64'd0);
            end
        end
    endtask

    task automatic t_sample;
        pins = 16'hA5C3;
        load_ir(3'b100);
        check("R5 sample no float", {63'b0, flt}, 64'd0);
        scan(0, 16, 64'hFFFF, got);
        check("R5 sample capture", got, 64'hA5C3);
        check("R10 update-dr keeps float", {63'b0, flt}, 64'd0);
        pins = 16'h0F0F;
        scan(0, 16, 64'h1234, got);
        check("R10 no preload, pins seen", got, 64'h0F0F);
    endtask

    task automatic t_extest;
        pins = 16'h3C96;
        load_ir(3'b000);
        check("R2 float before update", {63'b0, pre_flt}, 64'd0);
        check("R6 extest float", {63'b0, flt}, 64'd1);
        scan(0, 16, 64'h5555, got);
        check("R6 extest capture", got, 64'h3C96);
        check("R10 float kept after update-dr", {63'b0, flt}, 64'd1);
    endtask

    task automatic t_samplez;
        load_ir(3'b111);
        pins = 16'h8001;
        load_ir(3'b010);
        check("R6 sample-z float", {63'b0, flt}, 64'd1);
        scan(0, 16, 64'd0, got);
        check("R6 sample-z capture", got, 64'h8001);
    endtask

    task automatic t_tlr_escape;
        load_ir(3'b000);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(1, 0);
        step(0, 0);
        check("R4 float cleared", {63'b0, flt}, 64'd0);
        check("R4 enable low", {63'b0, s_en}, 64'd0);
        scan(0, 32, 64'd0, got);
        check("R4 idcode restored", got, {32'b0, ID});
    endtask

    task automatic t_edge;
        logic a, b, c;
        load_ir(3'b111);
        step(1, 0);
        step(0, 0);
        step(0, 1);
        step(0, 1);
        a = s_tdo;
        @(posedge tck);
        #2;
        b = tdo;
        step(1, 1);
        c = s_tdo;
        step(1, 0);
        step(0, 0);
        check("R9 first bypass bit", {63'b0, a}, 64'd0);
        check("R9 held after rising edge", {63'b0, b}, 64'd0);
        check("R9 changed on falling edge", {63'b0, c}, 64'd1);
    endtask

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge tck);
        rst_n = 1'b1;
        tms   = 1'b0;
        step(0, 0);
        t_reset();
        t_ir_path();
        t_bypass();
        t_reserved();
        t_sample();
        t_extest();
        t_samplez();
        t_tlr_escape();
        t_edge();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule